// File: doc/BRIEF.md
# UART interrupt identification and priority

This block is the interrupt logic of a PC-style UART. It watches five interrupt sources: receiver line errors, received data at or above a fill threshold, receive character timeout, transmitter holding space empty, and modem line changes. It holds a pending state for each source and applies a four-bit enable mask. It drives one active-high interrupt request and a four-bit identification code for the highest-priority enabled source.

The serial engines, the receive and transmit FIFOs and the bus-side register decoder are outside this block. They supply one-cycle event pulses, the FIFO fill count and level, the raw modem inputs, and one-cycle strobes that mark reads and writes of specific registers. Each source is cleared by its own rule, tied to those strobes or to the receive fill level.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, `irq` is 0 and `iid` is 0001.
- R2: A pulse on any of `ovr_evt`, `par_evt`, `frm_evt` or `brk_evt` makes line status pending. It stays pending until `lsr_rd`. With enable bit 2 set, it shows as code 0110.
- R3: Data-available is a level and holds no state. In FIFO mode (`fifo_en`=1) it is true while `rx_count >= rx_trig`. In non-FIFO mode it is true while `rx_count != 0`. It clears as soon as the condition goes false. With enable bit 0 set, it shows as code 0100.
- R4: A `tmo_evt` pulse makes timeout pending. Only `rbr_rd` clears it. With enable bit 0 set, it shows as code 1100.
- R5: Transmitter-empty becomes pending on a rising edge of `tx_fifo_empty` in FIFO mode, and on a `thr_xfer` pulse in non-FIFO mode. The other input has no effect in each mode. With enable bit 1 set, it shows as code 0010.
- R6: `thr_wr` clears transmitter-empty. `iir_rd` also clears it, but only in a cycle where `iid` shows 0010.
- R7: A change on any of `cts_n`, `dsr_n`, `ri_n` or `dcd_n` makes modem status pending. `msr_rd` clears it. With enable bit 3 set, it shows as code 0000.
- R8: Priority from highest to lowest is: line status, data-available, timeout, transmitter-empty, modem status.
- R9: A source whose enable bit is 0 has no effect on `irq` or `iid`. Its pending state is kept, and it appears once the bit is set.
- R10: `irq` is the OR of all enabled pending sources. `iid` is 0001 exactly when `irq` is 0.
- R11: When a source's set event and its clear strobe arrive in the same cycle, the source is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier | input | 4 | Enables: bit0 data-available/timeout, bit1 transmitter-empty, bit2 line status, bit3 modem |
| fifo_en | input | 1 | 1 = FIFO mode |
| ovr_evt | input | 1 | Overrun event pulse |
| par_evt | input | 1 | Parity error event pulse |
| frm_evt | input | 1 | Framing error event pulse |
| brk_evt | input | 1 | Break event pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_count | input | CW | Receive fill count |
| rx_trig | input | CW | Receive trigger level |
| tmo_evt | input | 1 | Character timeout event pulse |
| rbr_rd | input | 1 | Receive buffer read strobe |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| thr_xfer | input | 1 | Holding-to-shift transfer pulse (non-FIFO mode) |
| thr_wr | input | 1 | Transmit holding write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| msr_rd | input | 1 | Modem status register read strobe |
| irq | output | 1 | Interrupt request, active high |
| iid | output | 4 | Identification code |

## Verification
The assertions assume that the event inputs and the read and write strobes are pulses synchronous to `clk`. They assume the modem inputs are already synchronized and held inactive (high) through reset, so that no change is seen at reset release. In FIFO mode they assume `rx_trig` is at least 1. The stimulus drives every input at the falling clock edge, holds each pulse for exactly one cycle, and keeps the modem lines high and `tx_fifo_empty` low during reset. A toggled modem line keeps its new level, so each toggle counts as exactly one change.

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ier,
  input  logic          fifo_en,
  input  logic          ovr_evt,
  input  logic          par_evt,
  input  logic          frm_evt,
  input  logic          brk_evt,
  input  logic          lsr_rd,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  input  logic          tmo_evt,
  input  logic          rbr_rd,
  input  logic          tx_fifo_empty,
  input  logic          thr_xfer,
  input  logic          thr_wr,
  input  logic          iir_rd,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          ri_n,
  input  logic          dcd_n,
  input  logic          msr_rd,
  output logic          irq,
  output logic [3:0]    iid
);
  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LS   = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_TMO  = 4'b1100;
  localparam logic [3:0] ID_THRE = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;

  logic       ls_p, to_p, th_p, ms_p;
  logic       txe_q;
  logic [3:0] mdm_q;
  logic       ls_set, th_set, ms_set, th_clr, rda;
  logic       ls_a, rda_a, to_a, th_a, ms_a;

  assign ls_set = ovr_evt | par_evt | frm_evt | brk_evt;
  assign th_set = fifo_en ? (tx_fifo_empty & ~txe_q) : thr_xfer;
  assign ms_set = |({cts_n, dsr_n, ri_n, dcd_n} ^ mdm_q);
  assign rda    = fifo_en ? (rx_count >= rx_trig) : (rx_count != '0);
  assign th_clr = thr_wr | (iir_rd & (iid == ID_THRE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_p  <= 1'b0;
      to_p  <= 1'b0;
      th_p  <= 1'b0;
      ms_p  <= 1'b0;
      txe_q <= 1'b1;
      mdm_q <= 4'hF;
    end else begin
      txe_q <= tx_fifo_empty;
      mdm_q <= {cts_n, dsr_n, ri_n, dcd_n};
      if (ls_set)       ls_p <= 1'b1;
      else if (lsr_rd)  ls_p <= 1'b0;
      if (tmo_evt)      to_p <= 1'b1;
      else if (rbr_rd)  to_p <= 1'b0;
      if (th_set)       th_p <= 1'b1;
      else if (th_clr)  th_p <= 1'b0;
      if (ms_set)       ms_p <= 1'b1;
      else if (msr_rd)  ms_p <= 1'b0;
    end
  end

  assign ls_a  = ls_p & ier[2];
  assign rda_a = rda  & ier[0];
  assign to_a  = to_p & ier[0];
  assign th_a  = th_p & ier[1];
  assign ms_a  = ms_p & ier[3];
  assign irq   = ls_a | rda_a | to_a | th_a | ms_a;

  always_comb begin
    if (ls_a)       iid = ID_LS;
    else if (rda_a) iid = ID_RDA;
    else if (to_a)  iid = ID_TMO;
    else if (th_a)  iid = ID_THRE;
    else if (ms_a)  iid = ID_MS;
    else            iid = ID_NONE;
  end

  a_r2_ls_set: assert property (@(posedge clk) disable iff (!rst_n)
    ls_set |=> ls_p);
  a_r2_ls_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_p && !lsr_rd) |=> ls_p);
  a_r4_tmo_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !tmo_evt) |=> !to_p);
  a_r6_thre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !th_set) |=> !th_p);
  a_r7_ms_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ms_set) |=> !ms_p);
  a_r8_ls_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_p && ier[2]) |-> iid == ID_LS);
  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> iid == ID_NONE);
  a_r10_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> iid != ID_NONE);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_set && lsr_rd) |=> ls_p);
endmodule

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb;
  localparam int CW = 5;
  logic clk = 0, rst_n = 0;
  logic [3:0] ier = 0;
  logic fifo_en = 1;
  logic ovr_evt = 0, par_evt = 0, frm_evt = 0, brk_evt = 0, lsr_rd = 0;
  logic [CW-1:0] rx_count = 0, rx_trig = 4;
  logic tmo_evt = 0, rbr_rd = 0;
  logic tx_fifo_empty = 0, thr_xfer = 0, thr_wr = 0, iir_rd = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1, msr_rd = 0;
  logic irq;
  logic [3:0] iid;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_id #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ier(ier), .fifo_en(fifo_en),
    .ovr_evt(ovr_evt), .par_evt(par_evt), .frm_evt(frm_evt), .brk_evt(brk_evt),
    .lsr_rd(lsr_rd), .rx_count(rx_count), .rx_trig(rx_trig),
    .tmo_evt(tmo_evt), .rbr_rd(rbr_rd), .tx_fifo_empty(tx_fifo_empty),
    .thr_xfer(thr_xfer), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .msr_rd(msr_rd), .irq(irq), .iid(iid));

  function automatic logic [3:0] exp_id(input logic [3:0] e, input logic [4:0] s);
    if (s[0] && e[2]) return 4'b0110;
    if (s[1] && e[0]) return 4'b0100;
    if (s[2] && e[0]) return 4'b1100;
    if (s[3] && e[1]) return 4'b0010;
    if (s[4] && e[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    logic exp_irq;
    #1;
    exp_irq = (exp != 4'b0001);
    n_chk++;
    if (iid !== exp || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp, exp_irq);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    lsr_rd = 1; rbr_rd = 1; thr_wr = 1; msr_rd = 1; rx_count = 0;
    step();
    lsr_rd = 0; rbr_rd = 0; thr_wr = 0; msr_rd = 0;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 reset", 4'b0001);
    rst_n = 1;
    step();
    ier = 4'hF;
    chk("R1 after release", 4'b0001);

    // R8 R9 R10 sweep over every enable mask and pending combination
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 32; s++) begin
        logic [4:0] sv;
        sv = s[4:0];
        ier = e[3:0];
        rx_count = sv[1] ? rx_trig : '0;
        ovr_evt = sv[0]; tmo_evt = sv[2]; tx_fifo_empty = sv[3];
        if (sv[4]) cts_n = ~cts_n;
        step();
        ovr_evt = 0; tmo_evt = 0; tx_fifo_empty = 0;
        chk("R8/R9/R10 sweep", exp_id(e[3:0], sv));
        clear_all();
        chk("R10 cleared", 4'b0001);
      end
    end

    ier = 4'hF;
    // R2 each error kind
    par_evt = 1; step(); par_evt = 0; chk("R2 parity", 4'b0110);
    step(); chk("R2 held", 4'b0110);
    lsr_rd = 1; step(); lsr_rd = 0; chk("R2 cleared", 4'b0001);
    frm_evt = 1; step(); frm_evt = 0; chk("R2 framing", 4'b0110);
    clear_all();
    brk_evt = 1; step(); brk_evt = 0; chk("R2 break", 4'b0110);
    clear_all();

    // R3 threshold, FIFO mode
    rx_trig = 8;
    rx_count = 7; chk("R3 below trigger", 4'b0001);
    rx_count = 8; chk("R3 at trigger", 4'b0100);
    rx_count = 9; chk("R3 above trigger", 4'b0100);
    rx_count = 7; chk("R3 drops below", 4'b0001);
    fifo_en = 0;
    rx_count = 1; chk("R3 non-FIFO one char", 4'b0100);
    rx_count = 0; chk("R3 non-FIFO empty", 4'b0001);
    fifo_en = 1;

    // R4 timeout cleared only by buffer read
    tmo_evt = 1; step(); tmo_evt = 0; chk("R4 timeout", 4'b1100);
    lsr_rd = 1; msr_rd = 1; thr_wr = 1; step(); lsr_rd = 0; msr_rd = 0; thr_wr = 0;
    chk("R4 other clears ignored", 4'b1100);
    rbr_rd = 1; step(); rbr_rd = 0; chk("R4 cleared", 4'b0001);

    // R5 mode selection of transmitter-empty source
    thr_xfer = 1; step(); thr_xfer = 0; chk("R5 FIFO mode ignores transfer", 4'b0001);
    tx_fifo_empty = 1; step(); chk("R5 FIFO empty edge", 4'b0010);
    thr_wr = 1; step(); thr_wr = 0; chk("R6 write clears, level held", 4'b0001);
    tx_fifo_empty = 0; step();
    fifo_en = 0;
    tx_fifo_empty = 1; step(); chk("R5 non-FIFO ignores empty edge", 4'b0001);
    tx_fifo_empty = 0;
    thr_xfer = 1; step(); thr_xfer = 0; chk("R5 non-FIFO transfer", 4'b0010);
    fifo_en = 1;

    // R6 id read clears only when transmitter-empty is shown
    ovr_evt = 1; step(); ovr_evt = 0; chk("R8 line status over transmitter", 4'b0110);
    iir_rd = 1; step(); iir_rd = 0;
    lsr_rd = 1; step(); lsr_rd = 0; chk("R6 id read kept transmitter-empty", 4'b0010);
    iir_rd = 1; step(); iir_rd = 0; chk("R6 id read cleared", 4'b0001);

    // R7 each modem line
    dsr_n = 0; step(); chk("R7 dsr change", 4'b0000);
    msr_rd = 1; step(); msr_rd = 0; chk("R7 cleared", 4'b0001);
    ri_n = 0; step(); chk("R7 ring change", 4'b0000);
    clear_all();
    dcd_n = 0; step(); chk("R7 carrier change", 4'b0000);
    clear_all();

    // R9 masked source kept pending
    ier = 4'h0;
    brk_evt = 1; step(); brk_evt = 0; chk("R9 masked", 4'b0001);
    step();
    ier = 4'b0100; chk("R9 appears when enabled", 4'b0110);
    clear_all();

    // R11 set and clear in same cycle
    ier = 4'hF;
    ovr_evt = 1; lsr_rd = 1; step(); ovr_evt = 0; lsr_rd = 0;
    chk("R11 line status set wins", 4'b0110);
    clear_all();
    tmo_evt = 1; rbr_rd = 1; step(); tmo_evt = 0; rbr_rd = 0;
    chk("R11 timeout set wins", 4'b1100);
    clear_all();
    chk("R11 final clear", 4'b0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule